// File: doc/BRIEF.md
# Predicate-Driven Conditional Row Fetch

This block sequences the configuration rows of a small coarse-grained reconfigurable array. Every row of the instruction memory carries one configuration slot for each processing element plus a header, and the block issues one row per cycle to the whole array. A row whose header marks a compare also carries a conditional number and a group length k. The fetch unit records k for that conditional in a small lookup buffer. When a processing element later returns the predicate with the conditional number, the unit issues one of the two k-row groups that follow the compare and steps over the other. Only useful work reaches the array, and no element needs predicate registers.

True groups end in a jump over their paired false group. These pending jumps sit on a small stack, so conditionals may nest inside either path, and inner regions close before outer ones. The unit runs a modulo-scheduled kernel between a programmed first and last row. It wraps back to the first row at the end of each pass and stops after a programmed number of passes. If a predicate has not arrived when a decision is due, the unit stalls and sends an all-idle row.

Top module: `cgra_cond_fetch`

## Requirements
- R1: After reset the unit is stopped: busy_o, issue_o, done_o and err_o are low and row_o is all zero.
- R2: A start_i pulse while stopped latches the first row, last row and pass count. From the next cycle the unit issues consecutive rows from the first row, one per cycle, with row_o equal to row_i at pc_o and issue_o high.
- R3: A row is a compare when its top bit is 1. The next ID_W bits below it give the conditional number and the K_W bits below those give k. Issuing such a row stores k for that number in the lookup buffer. A predicate in the same cycle already sees the new value.
- R4: A true predicate issues the k rows that follow the compare, then continues at compare+1+2k and steps over the next k rows.
- R5: A false predicate steps over the k rows that follow the compare and issues the k rows after them.
- R6: A predicate accepted in cycle t (the cycle the compare row is issued, or any stall cycle after it) picks the row issued in cycle t+1. While none arrives, issue_o is low, row_o is all zero (the idle encoding) and pc_o holds.
- R7: Up to DEPTH true regions may be pending at once. The innermost region closes first, and regions that end on the same row all close in one step with no extra cycle.
- R8: When the next row would pass the last row, the unit returns to the first row. When the pass count is reached (a count of 0 counts as 1) it stops instead: done_o pulses for one cycle and busy_o falls in the same cycle.
- R9: A predicate for a conditional number that has not been stored in the lookup buffer pulses err_o one cycle later and is treated as false with k=0.
- R10: A predicate that arrives while the unit is stopped, or while it issues a row that is not a compare, has no effect.
- R11: A compare with k=0 makes both groups empty, and the unit continues at the row after the compare whatever the predicate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (ignored while busy) |
| loop_start_i | input | ADDR_W | First kernel row |
| loop_end_i | input | ADDR_W | Last kernel row |
| trip_i | input | CNT_W | Number of kernel passes |
| pc_o | output | ADDR_W | Row address to the instruction memory |
| row_i | input | ROW_W | Row read at pc_o (same cycle) |
| row_o | output | ROW_W | Row sent to the array, all zero when idle |
| issue_o | output | 1 | row_o carries a fetched row |
| pred_valid_i | input | 1 | Predicate return strobe |
| pred_id_i | input | ID_W | Conditional number of the predicate |
| pred_val_i | input | 1 | Predicate value |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when the run ends |
| err_o | output | 1 | One-cycle pulse on an unknown conditional |

## Verification
Within a cycle, row_o and issue_o follow the state and row_i. A predicate or start pulse shows up in pc_o and row_o one clock edge later, and err_o and done_o are registered, so each pulses one edge after its cause. The bench drives inputs just after the rising edge and steps a queue-based reference model on that same edge. It compares every output at the falling edge, so each expected value is checked in exactly the cycle it is due. Predicates are returned with varying delays, including none, so the stall and the same-cycle path are both covered.

// File: rtl/cgra_fetch_pkg.sv
package cgra_fetch_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2
  } fetch_state_e;
endpackage

// File: rtl/cond_lut.sv
module cond_lut #(
  parameter int ID_W = 2,
  parameter int K_W  = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [ID_W-1:0] wr_id_i,
  input  logic [K_W-1:0]  wr_k_i,
  input  logic [ID_W-1:0] rd_id_i,
  output logic [K_W-1:0]  rd_k_o,
  output logic            hit_o
);
  localparam int NENT = 1 << ID_W;

  logic [K_W-1:0]  k_q [NENT];
  logic [NENT-1:0] v_q;
  logic            byp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      for (int i = 0; i < NENT; i++) k_q[i] <= '0;
    end else if (we_i) begin
      v_q[wr_id_i] <= 1'b1;
      k_q[wr_id_i] <= wr_k_i;
    end
  end

  // same-cycle write is visible to a predicate for the same conditional
  always_comb begin
    byp    = we_i && (wr_id_i == rd_id_i);
    hit_o  = byp || v_q[rd_id_i];
    rd_k_o = byp ? wr_k_i : k_q[rd_id_i];
  end

  // R3
  stored_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (hit_o || (rd_id_i != $past(wr_id_i))));
endmodule

// File: rtl/skip_stack.sv
module skip_stack #(
  parameter int PW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [PW-1:0] probe_i,
  input  logic          adv_i,
  input  logic          push_i,
  input  logic [PW-1:0] push_end_i,
  input  logic [PW-1:0] push_res_i,
  output logic [PW-1:0] probe_o
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PW-1:0]  end_q [DEPTH];
  logic [PW-1:0]  res_q [DEPTH];
  logic [SPW-1:0] sp_q, sp_aft, npop;
  logic [IW-1:0]  ix;
  logic           go;

  // walk from the top while region ends coincide with the probed row
  always_comb begin
    probe_o = probe_i;
    npop    = '0;
    go      = 1'b1;
    ix      = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if (go && (SPW'(j) < sp_q)) begin
        ix = IW'(sp_q - SPW'(j + 1));
        if (end_q[ix] == probe_o) begin
          probe_o = res_q[ix];
          npop    = npop + SPW'(1);
        end else begin
          go = 1'b0;
        end
      end
    end
    sp_aft = adv_i ? (sp_q - npop) : sp_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        end_q[i] <= '0;
        res_q[i] <= '0;
      end
    end else if (clr_i) begin
      sp_q <= '0;
    end else if (push_i && (sp_aft < SPW'(DEPTH))) begin
      end_q[IW'(sp_aft)] <= push_end_i;
      res_q[IW'(sp_aft)] <= push_res_i;
      sp_q <= sp_aft + SPW'(1);
    end else begin
      sp_q <= sp_aft;
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !clr_i) |-> (sp_aft < SPW'(DEPTH)));
endmodule

// File: rtl/cgra_cond_fetch.sv
module cgra_cond_fetch
  import cgra_fetch_pkg::*;
#(
  parameter int N_PE   = 4,
  parameter int SLOT_W = 8,
  parameter int ADDR_W = 6,
  parameter int ID_W   = 2,
  parameter int K_W    = 4,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 8,
  localparam int ROW_W = 1 + ID_W + K_W + N_PE * SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] loop_start_i,
  input  logic [ADDR_W-1:0] loop_end_i,
  input  logic [CNT_W-1:0]  trip_i,
  output logic [ADDR_W-1:0] pc_o,
  input  logic [ROW_W-1:0]  row_i,
  output logic [ROW_W-1:0]  row_o,
  output logic              issue_o,
  input  logic              pred_valid_i,
  input  logic [ID_W-1:0]   pred_id_i,
  input  logic              pred_val_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int PW = ((ADDR_W > K_W) ? ADDR_W : K_W) + 2;

  fetch_state_e      state_q;
  logic [ADDR_W-1:0] pc_q, ls_q, le_q;
  logic [CNT_W-1:0]  trip_q, iter_q;
  logic              done_q, err_q;

  logic              row_cmp, is_cmp, issuing, resolve, push, moving, wrap, last;
  logic [ID_W-1:0]   row_id;
  logic [K_W-1:0]    row_k, lut_k;
  logic              lut_hit;
  logic [PW-1:0]     stk_pc, base, k_eff, tgt, push_end, push_res;

  assign row_cmp = row_i[ROW_W-1];
  assign row_id  = row_i[ROW_W-2 -: ID_W];
  assign row_k   = row_i[ROW_W-2-ID_W -: K_W];

  assign issuing = (state_q == ST_RUN);
  assign is_cmp  = issuing && row_cmp;
  assign issue_o = issuing;
  assign row_o   = issuing ? row_i : '0;
  assign pc_o    = pc_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign err_o   = err_q;

  cond_lut #(.ID_W(ID_W), .K_W(K_W)) u_lut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (is_cmp),
    .wr_id_i (row_id),
    .wr_k_i  (row_k),
    .rd_id_i (pred_id_i),
    .rd_k_o  (lut_k),
    .hit_o   (lut_hit)
  );

  skip_stack #(.PW(PW), .DEPTH(DEPTH)) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      ((moving && wrap) || (state_q == ST_IDLE)),
    .probe_i    (PW'(pc_q) + PW'(1)),
    .adv_i      (issuing),
    .push_i     (push),
    .push_end_i (push_end),
    .push_res_i (push_res),
    .probe_o    (stk_pc)
  );

  always_comb begin
    resolve  = pred_valid_i && (is_cmp || (state_q == ST_WAIT));
    base     = (state_q == ST_WAIT) ? PW'(pc_q) : stk_pc;
    k_eff    = lut_hit ? PW'(lut_k) : '0;
    push     = resolve && pred_val_i && (k_eff != '0);
    push_end = base + k_eff;
    push_res = base + (k_eff << 1);
    tgt      = (resolve && !pred_val_i) ? (base + k_eff) : base;
    moving   = issuing || resolve;
    wrap     = tgt > PW'(le_q);
    last     = ({1'b0, iter_q} + (CNT_W+1)'(1)) >= {1'b0, trip_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      ls_q    <= '0;
      le_q    <= '0;
      trip_q  <= '0;
      iter_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= resolve && !lut_hit;
      if (state_q == ST_IDLE) begin
        if (start_i) begin
          state_q <= ST_RUN;
          pc_q    <= loop_start_i;
          ls_q    <= loop_start_i;
          le_q    <= loop_end_i;
          trip_q  <= trip_i;
          iter_q  <= '0;
        end
      end else if (moving) begin
        if (wrap && last) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end else begin
          state_q <= (is_cmp && !pred_valid_i) ? ST_WAIT : ST_RUN;
          if (wrap) begin
            pc_q   <= ls_q;
            iter_q <= iter_q + CNT_W'(1);
          end else begin
            pc_q <= tgt[ADDR_W-1:0];
          end
        end
      end
    end
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !issue_o && !pred_valid_i) |=> (!issue_o && $stable(pc_o)));

  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R9
  err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(pred_valid_i));
endmodule

// File: tb/tb_cgra_cond_fetch.sv
module tb_cgra_cond_fetch;
  localparam int ROW_W = 1 + 2 + 4 + 4 * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             start = 1'b0;
  logic [5:0]       ls = '0, le = '0;
  logic [7:0]       trip = '0;
  logic [5:0]       pc;
  logic [ROW_W-1:0] row_in, row_out;
  logic             issue, busy, done, err;
  logic             pv = 1'b0, pval = 1'b0;
  logic [1:0]       pid = '0;
  logic [ROW_W-1:0] mem [64];

  assign row_in = mem[pc];

  cgra_cond_fetch dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .loop_start_i(ls), .loop_end_i(le), .trip_i(trip),
    .pc_o(pc), .row_i(row_in), .row_o(row_out), .issue_o(issue),
    .pred_valid_i(pv), .pred_id_i(pid), .pred_val_i(pval),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  int checks = 0, errors = 0, run = 0, cyc = 0, r3_cnt = 0, r3_done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [ROW_W-1:0] mk(input bit c, input int id, input int k, input int r);
    return {c, 2'(id), 4'(k), 8'(r + 1), 8'(r + 17), 8'd0, 8'(r + 33)};
  endfunction

  // reference model
  int ms = 0, mpc = 0, mit = 0, mpend = 0;
  bit exp_err = 0, exp_done = 0;
  int se[$], sr[$];
  int lut_k[4];
  bit lut_v[4];

  task automatic m_goto(input int t);
    if (t > int'(le)) begin
      mit++;
      se.delete(); sr.delete();
      if (mit >= int'(trip)) begin ms = 0; exp_done = 1; end
      else mpc = int'(ls);
    end else mpc = t;
  endtask

  task automatic m_resolve(input int b);
    int kk;
    kk = lut_v[pid] ? lut_k[pid] : 0;
    exp_err = !lut_v[pid];
    ms = 1;
    if (pval && kk != 0) begin se.push_back(b + kk); sr.push_back(b + 2 * kk); end
    m_goto(pval ? b : b + kk);
  endtask

  always @(posedge clk) begin
    logic [ROW_W-1:0] r;
    int nxt;
    exp_err = 0; exp_done = 0;
    if (!rst_n) begin
      ms = 0; mpc = 0; mit = 0; se.delete(); sr.delete();
      for (int i = 0; i < 4; i++) lut_v[i] = 0;
    end else begin
      case (ms)
        0: if (start) begin mpc = int'(ls); mit = 0; ms = 1; se.delete(); sr.delete(); end
        1: begin
          r = mem[mpc];
          nxt = mpc + 1;
          while (se.size() > 0 && se[se.size()-1] == nxt) begin
            nxt = sr[sr.size()-1];
            void'(se.pop_back()); void'(sr.pop_back());
          end
          if (r[ROW_W-1]) begin
            lut_k[r[ROW_W-2 -: 2]] = int'(r[ROW_W-4 -: 4]);
            lut_v[r[ROW_W-2 -: 2]] = 1;
            if (pv) m_resolve(nxt);
            else begin ms = 2; mpend = int'(r[ROW_W-2 -: 2]); m_goto(nxt); end
          end else m_goto(nxt);
        end
        default: if (pv) m_resolve(mpc);
      endcase
    end
  end

  // predicate stimulus, applied just after the edge
  int wcnt = 0;
  always @(posedge clk) begin
    int cid, dly;
    bit at_cmp;
    #1;
    at_cmp = rst_n && ((ms == 1 && mem[mpc][ROW_W-1]) || ms == 2);
    cid = (ms == 2) ? mpend : int'(mem[mpc][ROW_W-2 -: 2]);
    if (at_cmp) begin
      dly = (run == 3) ? 0 : (mit + cid) % 3;
      if (wcnt >= dly) begin
        pv = 1;
        pid = (run == 2 && cid == 2) ? 2'd3 : 2'(cid);
        pval = (run == 3) ? 1'b0 : 1'(((mit >> cid) & 1) ^ (run == 2 ? 1 : 0));
        wcnt = 0;
      end else begin
        pv = 0; wcnt++;
      end
    end else begin
      wcnt = 0;
      // R10: stray predicate on a plain row or while stopped
      pv = (run == 1 && ((ms == 1 && mpc == 0) || ms == 0));
      pid = 2'd0; pval = 1'b1;
    end
  end

  // per-cycle comparison at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (rst_n) begin
      chk(issue == (ms == 1), "R2 R6 issue_o", issue, ms == 1);
      if (ms == 1) begin
        chk(pc == 6'(mpc), "R4 R5 R7 R10 R11 pc_o", pc, mpc);
        chk(row_out == mem[mpc], "R2 row_o", row_out, mem[mpc]);
      end else begin
        chk(row_out == '0, "R6 idle row", row_out, 0);
      end
      chk(err == exp_err, "R9 err_o", err, exp_err);
      chk(done == exp_done, "R8 done_o", done, exp_done);
      chk(busy == (ms != 0), "R8 busy_o", busy, ms != 0);
      if (run == 3 && issue) r3_cnt++;
      if (run == 3 && done) r3_done++;
    end
  end

  task automatic do_run(input int rn, input int tp);
    run = rn;
    ls = 6'd0; le = 6'd11; trip = 8'(tp);
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk); #2;
      if (ms == 0) break;
    end
    repeat (3) @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    for (int i = 0; i < 12; i++) mem[i] = mk(0, 0, 0, i);
    mem[1]  = mk(1, 0, 4, 1);   // outer, groups 2..5 / 6..9
    mem[3]  = mk(1, 1, 1, 3);   // inner in true path
    mem[7]  = mk(1, 2, 1, 7);   // inner in false path
    mem[10] = mk(1, 1, 0, 10);  // empty groups (R11)
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(!busy && !issue && !done && !err, "R1 flags", {busy, issue, done, err}, 0);
    chk(row_out == '0, "R1 row_o", row_out, 0);
    @(negedge clk); rst_n = 1'b1;
    do_run(1, 6);   // R3 R4 R5 R6 R7 R10 mixed outcomes and delays
    do_run(2, 2);   // R9 unknown conditional
    do_run(3, 0);   // R8 zero pass count, all false, no stall
    // R5 R11: rows 0,1,6,7,9,10,11
    chk(r3_cnt == 7, "R5 R11 issued rows", r3_cnt, 7);
    chk(r3_done == 1, "R8 single done pulse", r3_done, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule